// File: doc/BRIEF.md
# Dual-mode audio serial receiver

This block takes a stream of 16-bit stereo samples in two's complement, sent most significant bit first, and turns them into a left and a right sample register. The bit clock of the stream is the block's clock. All input transitions happen on its falling edge, and the block samples on the rising edge. A word is right-justified: its last bit is the one sampled just before the frame clock marks a boundary. Any extra bit clocks before the most significant bit therefore drop out.

A static mode input picks one of two formats that share the same pins. In shared-line mode, left and right words alternate on one data line. Every change of the frame clock ends a word. The second data pin then acts as a polarity select that decides which frame clock level carries the left channel. In dual-line mode, the left and right words arrive together on the two data lines. Only a falling frame clock edge ends a word pair.

Both sample registers update on the same clock edge, four and a half bit clocks after the boundary, with a one-cycle strobe. For each channel the block also presents an offset-binary code, meant for a resistor-string converter.

Top module: `audio_pair_rx`

## Requirements
- R1: Data is sampled on the rising edge of `clk`, most significant bit first. The completed word is the last 16 bits sampled before the boundary is seen, so extra leading bits within a frame have no effect.
- R2: With `dual_mode` low, every change of `frame_clk` is a boundary. The completed word belongs to the left channel when (`frame_clk` level during the word) XOR `sdata_b` is 1, and to the right channel otherwise. In this mode `sdata_b` is a static polarity select.
- R3: In shared-line mode the outputs change only after one left word and one right word have both been captured since the last update. The earlier word of a pair is held until its partner completes.
- R4: With `dual_mode` high, only a falling edge of `frame_clk` is a boundary. `sdata_a` carries the left word and `sdata_b` carries the right word of the same frame. A rising edge of `frame_clk` has no effect.
- R5: `left_pcm`, `right_pcm` and `update` change together on the fifth rising edge after the edge that sampled the LSB, which is 4.5 bit clocks after the boundary falling edge. `update` is high for exactly one cycle.
- R6: `left_code` and `right_code` equal `left_pcm` and `right_pcm` with bit 15 inverted: 0x7FFF gives 0xFFFF, 0x0000 gives 0x8000, 0x8000 gives 0x0000.
- R7: Between updates, `left_pcm` and `right_pcm` hold their values.
- R8: A synchronous active-high `rst` sets both sample registers to 0, both codes to 0x8000 and `update` to 0. A boundary that comes fewer than 16 sampled bits after reset or after the previous boundary is discarded and takes no part in pairing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; data sampled on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dual_mode | input | 1 | 0: shared-line format, 1: dual-line format (static) |
| frame_clk | input | 1 | Channel clock (shared-line) or word clock (dual-line) |
| sdata_a | input | 1 | Serial data: both channels (shared-line) or left (dual-line) |
| sdata_b | input | 1 | Channel polarity select (shared-line) or right serial data (dual-line) |
| left_pcm | output | 16 | Latched left sample, two's complement |
| right_pcm | output | 16 | Latched right sample, two's complement |
| left_code | output | 16 | Left sample as offset-binary code |
| right_code | output | 16 | Right sample as offset-binary code |
| update | output | 1 | One-cycle strobe when both samples change |

## Verification
The properties assume the following about the inputs:
- `dual_mode`, and in shared-line mode the polarity on `sdata_b`, stay constant while out of reset.
- `frame_clk` and the data lines change only at falling edges of `clk`.
- Two boundaries are never closer together than five bit clocks.

The delay property is checked against the most recent boundary seen at the ports, so it depends on that spacing. The stimulus respects all of this:
- Every input is driven at a falling edge.
- Mode and polarity are set only while `rst` is held.
- Frames are whole words, padded in front where leading bits are tested.
- The only short frame is the deliberately partial one right after reset.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_LANES = 2;
    localparam int UPD_EDGES = 4;
    localparam int CNT_W     = $clog2(WORD_W + 1);
    localparam int DLY_W     = $clog2(UPD_EDGES + 1);

    typedef logic [WORD_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    typedef enum logic {
        FMT_SHARED = 1'b0,
        FMT_DUAL   = 1'b1
    } fmt_e;

    // Two's complement to offset binary: flip the sign bit.
    function automatic sample_t to_offset(sample_t s);
        return {~s[WORD_W-1], s[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/arx_frame_detect.sv
module arx_frame_detect
    import audio_rx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  fmt_e fmt,
    input  logic frame_in,
    output logic word_done,
    output logic frame_lvl
);
    localparam int CW = $clog2(W + 1);

    logic          frame_q;
    logic [CW-1:0] bit_cnt;
    logic          edge_seen;
    logic          full;

    always_comb begin
        full      = (bit_cnt >= CW'(W));
        edge_seen = (fmt == FMT_DUAL) ? (frame_q & ~frame_in)
                                      : (frame_q ^ frame_in);
    end

    // A boundary counts only if a whole word was shifted in since the last one.
    assign word_done = edge_seen & full;
    assign frame_lvl = frame_q;

    always_ff @(posedge clk) begin
        frame_q <= frame_in;
        if (rst) begin
            bit_cnt <= '0;
        end else if (edge_seen) begin
            // The boundary edge already samples the first bit of the next word.
            bit_cnt <= CW'(1);
        end else if (!full) begin
            bit_cnt <= bit_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/arx_lane_shift.sv
module arx_lane_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) word <= '0;
        else     word <= {word[W-2:0], din};
    end
endmodule

// File: rtl/arx_update_ctrl.sv
module arx_update_ctrl
    import audio_rx_pkg::*;
#(
    parameter int DELAY = UPD_EDGES
) (
    input  logic    clk,
    input  logic    rst,
    input  fmt_e    fmt,
    input  logic    word_done,
    input  logic    chan_left,
    input  sample_t word_a,
    input  sample_t word_b,
    output stereo_t pcm,
    output logic    strobe
);
    localparam int DW = $clog2(DELAY + 1);

    stereo_t       stage;
    logic          have_l;
    logic          have_r;
    logic [DW-1:0] dly;
    logic          launch;

    // A pair is complete in dual-line mode at once, in shared-line mode when
    // the partner channel is already waiting.
    always_comb begin
        launch = word_done &&
                 ((fmt == FMT_DUAL) || (chan_left ? have_r : have_l));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage  <= '0;
            have_l <= 1'b0;
            have_r <= 1'b0;
            dly    <= '0;
            pcm    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (word_done) begin
                if (fmt == FMT_DUAL) begin
                    stage <= {word_a, word_b};
                end else if (chan_left) begin
                    stage.left <= word_a;
                end else begin
                    stage.right <= word_a;
                end
                if (launch) begin
                    have_l <= 1'b0;
                    have_r <= 1'b0;
                end else if (fmt != FMT_DUAL) begin
                    if (chan_left) have_l <= 1'b1;
                    else           have_r <= 1'b1;
                end
            end
            if (launch) begin
                dly <= DW'(DELAY);
            end else if (dly != '0) begin
                dly <= dly - DW'(1);
                if (dly == DW'(1)) begin
                    pcm    <= stage;
                    strobe <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/audio_pair_rx.sv
module audio_pair_rx
    import audio_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dual_mode,
    input  logic              frame_clk,
    input  logic              sdata_a,
    input  logic              sdata_b,
    output logic [WORD_W-1:0] left_pcm,
    output logic [WORD_W-1:0] right_pcm,
    output logic [WORD_W-1:0] left_code,
    output logic [WORD_W-1:0] right_code,
    output logic              update
);
    fmt_e                 fmt;
    logic [NUM_LANES-1:0] lane_din;
    sample_t              lane_word [NUM_LANES];
    logic                 word_done;
    logic                 frame_lvl;
    logic                 chan_left;
    stereo_t              pcm;

    assign fmt      = fmt_e'(dual_mode);
    assign lane_din = {sdata_b, sdata_a};

    arx_frame_detect #(.W(WORD_W)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt),
        .frame_in  (frame_clk),
        .word_done (word_done),
        .frame_lvl (frame_lvl)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        arx_lane_shift #(.W(WORD_W)) u_shift (
            .clk  (clk),
            .rst  (rst),
            .din  (lane_din[g]),
            .word (lane_word[g])
        );
    end

    // Shared-line mode: sdata_b is the polarity select.
    assign chan_left = frame_lvl ^ sdata_b;

    arx_update_ctrl #(.DELAY(UPD_EDGES)) u_update (
        .clk       (clk),
        .rst       (rst),
        .fmt       (fmt),
        .word_done (word_done),
        .chan_left (chan_left),
        .word_a    (lane_word[0]),
        .word_b    (lane_word[1]),
        .pcm       (pcm),
        .strobe    (update)
    );

    assign left_pcm   = pcm.left;
    assign right_pcm  = pcm.right;
    assign left_code  = to_offset(pcm.left);
    assign right_code = to_offset(pcm.right);

endmodule

// File: rtl/audio_rx_checker.sv
module audio_rx_checker
    import audio_rx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              dual_mode,
    input logic              frame_clk,
    input logic [WORD_W-1:0] left_pcm,
    input logic [WORD_W-1:0] right_pcm,
    input logic [WORD_W-1:0] left_code,
    input logic [WORD_W-1:0] right_code,
    input logic              update
);
    logic       fq;
    logic [2:0] since;
    logic       bnd;

    assign bnd = dual_mode ? (fq & ~frame_clk) : (fq ^ frame_clk);

    // Cycles since the last boundary seen at the ports, saturating at 7.
    always_ff @(posedge clk) begin
        fq <= frame_clk;
        if (rst)                since <= 3'd7;
        else if (bnd)           since <= 3'd0;
        else if (since != 3'd7) since <= since + 3'd1;
    end

    // R5: strobe lasts one cycle
    a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
        update |=> !update);

    // R5: strobe comes a fixed count of edges after a boundary
    a_r5_fixed_delay: assert property (@(posedge clk) disable iff (rst)
        update |-> (since == 3'(UPD_EDGES)));

    // R7: samples move only with the strobe
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (!$stable(left_pcm) || !$stable(right_pcm)) |-> update);

    // R8: reset clears the sample registers and the strobe
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (left_pcm == '0 && right_pcm == '0 && !update));

    // R6: zero sample maps to mid-scale code
    a_r6_midscale: assert property (@(posedge clk) disable iff (rst)
        (left_pcm == '0 && right_pcm == '0) |->
            (left_code == 16'h8000 && right_code == 16'h8000));

endmodule

bind audio_pair_rx audio_rx_checker i_chk (
    .clk        (clk),
    .rst        (rst),
    .dual_mode  (dual_mode),
    .frame_clk  (frame_clk),
    .left_pcm   (left_pcm),
    .right_pcm  (right_pcm),
    .left_code  (left_code),
    .right_code (right_code),
    .update     (update)
);

// File: tb/test_audio_pair_rx.sv
module test_audio_pair_rx;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        dual;
        logic        pol;
        logic        lvl;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] exp_l;
        logic [15:0] exp_r;
    } vec_t;

    // Shared-line: left when lvl XOR pol is 1 (R2). Dual-line: a left, b right (R4).
    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 1'b1, 16'h1234, 16'hFEDC, 16'h1234, 16'hFEDC},
        '{1'b0, 1'b0, 1'b0, 16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF},
        '{1'b0, 1'b1, 1'b0, 16'h0001, 16'hFFFF, 16'h0001, 16'hFFFF},
        '{1'b0, 1'b1, 1'b1, 16'hA5A5, 16'h5A5A, 16'h5A5A, 16'hA5A5},
        '{1'b1, 1'b0, 1'b0, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF},
        '{1'b1, 1'b0, 1'b0, 16'h3C3C, 16'hC003, 16'h3C3C, 16'hC003}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dual_mode = 1'b0;
    logic        frame_clk = 1'b0;
    logic        sdata_a = 1'b0;
    logic        sdata_b = 1'b0;
    logic [15:0] left_pcm, right_pcm, left_code, right_code;
    logic        update;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audio_pair_rx i_audio_pair_rx (
        .clk        (clk),
        .rst        (rst),
        .dual_mode  (dual_mode),
        .frame_clk  (frame_clk),
        .sdata_a    (sdata_a),
        .sdata_b    (sdata_b),
        .left_pcm   (left_pcm),
        .right_pcm  (right_pcm),
        .left_code  (left_code),
        .right_code (right_code),
        .update     (update)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_pair(input string req, input logic [15:0] l, input logic [15:0] r);
        check({req, " left"}, left_pcm, l);
        check({req, " right"}, right_pcm, r);
    endtask

    task automatic do_reset(input logic dual, input logic pol, input logic lvl);
        @(negedge clk);
        rst       = 1'b1;
        dual_mode = dual;
        sdata_b   = dual ? 1'b0 : pol;
        frame_clk = lvl;
        sdata_a   = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // Sends n bits MSB first; frame level set at the first bit, optional rise.
    task automatic drive_word(input logic lvl, input int rise_at,
                              input logic [31:0] a, input logic [31:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 0)       frame_clk = lvl;
            if (i == rise_at) frame_clk = 1'b1;
            sdata_a = a[n-1-i];
            if (dual_mode) sdata_b = b[n-1-i];
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R8: reset state
        do_reset(1'b0, 1'b0, 1'b1);
        @(negedge clk);
        check_pair("R8 reset", 16'h0000, 16'h0000);
        check("R8 reset left_code", left_code, 16'h8000);
        check("R6 reset right_code", right_code, 16'h8000);
        check("R8 reset update", {15'd0, update}, 16'h0000);

        // Table walk: R2, R4, R6
        for (int v = 0; v < 6; v++) begin
            if (!VECS[v].dual) begin
                do_reset(1'b0, VECS[v].pol, VECS[v].lvl);
                drive_word(VECS[v].lvl, -1, {16'h0, VECS[v].a}, 32'h0, 16);
                drive_word(~VECS[v].lvl, -1, {16'h0, VECS[v].b}, 32'h0, 16);
                drive_word(VECS[v].lvl, -1, 32'h0, 32'h0, 16);
                check_pair("R2 table", VECS[v].exp_l, VECS[v].exp_r);
            end else begin
                do_reset(1'b1, 1'b0, 1'b1);
                drive_word(1'b0, 4, {16'h0, VECS[v].a}, {16'h0, VECS[v].b}, 16);
                drive_word(1'b0, 4, 32'h0, 32'h0, 16);
                check_pair("R4 table", VECS[v].exp_l, VECS[v].exp_r);
            end
            check("R6 left_code", left_code, VECS[v].exp_l ^ 16'h8000);
            check("R6 right_code", right_code, VECS[v].exp_r ^ 16'h8000);
        end

        // R5: cycle-exact strobe and simultaneous update
        do_reset(1'b0, 1'b0, 1'b1);
        drive_word(1'b1, -1, 32'h1111, 32'h0, 16);
        drive_word(1'b0, -1, 32'h2222, 32'h0, 16);
        @(negedge clk);
        frame_clk = 1'b1;
        sdata_a   = 1'b0;
        for (int j = 1; j <= 6; j++) begin
            @(negedge clk);
            check("R5 strobe", {15'd0, update}, (j == 5) ? 16'h0001 : 16'h0000);
            if (j == 4) check_pair("R5 before", 16'h0000, 16'h0000);
            if (j == 5) check_pair("R5 at update", 16'h1111, 16'h2222);
        end

        // R3 / R7: earlier word held until its partner completes
        do_reset(1'b0, 1'b0, 1'b1);
        drive_word(1'b1, -1, 32'h0A0A, 32'h0, 16);
        drive_word(1'b0, -1, 32'h0B0B, 32'h0, 16);
        drive_word(1'b1, -1, 32'h0C0C, 32'h0, 16);
        drive_word(1'b0, -1, 32'h0D0D, 32'h0, 16);
        check_pair("R3 first pair", 16'h0A0A, 16'h0B0B);
        drive_word(1'b1, -1, 32'h0, 32'h0, 4);
        check_pair("R7 hold", 16'h0A0A, 16'h0B0B);
        drive_word(1'b1, -1, 32'h0, 32'h0, 12);
        check_pair("R3 second pair", 16'h0C0C, 16'h0D0D);

        // R8: partial word after reset is discarded
        do_reset(1'b0, 1'b0, 1'b0);
        drive_word(1'b0, -1, 32'h3FF, 32'h0, 10);
        drive_word(1'b1, -1, 32'h4321, 32'h0, 16);
        drive_word(1'b0, -1, 32'h8765, 32'h0, 16);
        check_pair("R8 partial dropped", 16'h0000, 16'h0000);
        drive_word(1'b1, -1, 32'h0, 32'h0, 16);
        check_pair("R8 after partial", 16'h4321, 16'h8765);

        // R1: extra leading bits in a frame have no effect
        do_reset(1'b0, 1'b0, 1'b1);
        drive_word(1'b1, -1, 32'hABCD_1357, 32'h0, 32);
        drive_word(1'b0, -1, 32'h000F_2468, 32'h0, 20);
        drive_word(1'b1, -1, 32'h0, 32'h0, 16);
        check_pair("R1 leading bits", 16'h1357, 16'h2468);

        // R4: rising word clock mid-frame ignored, late rise position
        do_reset(1'b1, 1'b0, 1'b1);
        drive_word(1'b0, 13, 32'h0F0F, 32'hF0F0, 16);
        drive_word(1'b0, 3, 32'h0, 32'h0, 16);
        check_pair("R4 rise ignored", 16'h0F0F, 16'hF0F0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule